// File: doc/BRIEF.md
# Partitioned-Carry Packed SIMD Adder

This block adds two packed operand words as several independent narrow integers in one pass through a single wide adder. The word is built from 8-bit slices joined by one ripple carry chain. A run-time lane-width select decides where the chain is cut: at every slice for 8-bit lanes, every second slice for 16-bit lanes, or every fourth slice for 32-bit lanes. Each lane therefore wraps modulo its own width, and the carry leaving the top slice of each lane is reported.

Operands enter on a valid/ready stream, and the result leaves on a valid/ready stream one register later. The rules for back-pressure are as follows. An input beat is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the result and carry outputs hold, and no new input is taken. The lane-width select is sampled together with the operands.

The word width is a parameter and must be a multiple of 32. The default is 128 bits, and a 256-bit build is also supported.

Top module: `simd_lane_adder`

## Requirements
- R1: With `lane_mode` = 2'b00, every 8-bit lane k (bits 8k+7..8k) of `sum_o` equals the 8-bit lanes of the two operands added modulo 256.
- R2: With `lane_mode` = 2'b01, every 16-bit lane k (bits 16k+15..16k) of `sum_o` equals the operand lanes added modulo 65536.
- R3: With `lane_mode` = 2'b10, every 32-bit lane k (bits 32k+31..32k) of `sum_o` equals the operand lanes added modulo 2^32.
- R4: `lane_mode` = 2'b11 is reserved and gives exactly the 32-bit lane result of R3.
- R5: No carry crosses a lane boundary. A lane whose operands are all ones and 1 reads 0, and its upper neighbour is unaffected.
- R6: `carry_o` has one bit per 8-bit slice, and bit i belongs to bits 8i+7..8i. The bit at the top slice of each lane is that lane's carry out. Every other bit reads 0.
- R7: After an accepted input beat, `out_valid` is high on the next cycle and carries that beat's sum and carries. When no beat is accepted and `out_ready` is high, `out_valid` is low on the next cycle.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `sum_o`, `carry_o` and `out_valid` hold their values. When `out_valid` is low, `in_ready` is high.
- R9: Synchronous reset clears `out_valid`, and `in_ready` is high afterwards.
- R10: A 256-bit build performs eight independent 32-bit additions in one operation, and also sixteen 16-bit or thirty-two 8-bit additions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can take an operand beat |
| lane_mode | input | 2 | Lane width: 00 = 8, 01 = 16, 10 or 11 = 32 bits |
| opnd_a | input | WORD_W | First packed operand |
| opnd_b | input | WORD_W | Second packed operand |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| sum_o | output | WORD_W | Packed lane sums |
| carry_o | output | WORD_W/8 | Per-slice carry out, set only at lane tops |

## Verification
A wrong cut point in the carry chain shows at the ports on the first result whose lower lane overflows: a stray carry turns up as +1 in the lane above, or a carry is missing inside a wide lane. The error appears in the cycle after that beat is accepted. A wrong lane-top mask shows as a non-zero `carry_o` bit at an interior slice, or as a lost lane carry, on the same result. A faulty holding register shows as `sum_o` changing during a stall, or as a beat that is lost or duplicated once `out_ready` returns, within one cycle of the stall ending.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    LANE_W8   = 2'b00,
    LANE_W16  = 2'b01,
    LANE_W32  = 2'b10,
    LANE_RSVD = 2'b11
  } lane_mode_e;

  // slices per lane for a given mode; reserved code acts as 32-bit
  function automatic int slices_per_lane(input lane_mode_e m);
    case (m)
      LANE_W8:  return 1;
      LANE_W16: return 2;
      default:  return 4;
    endcase
  endfunction

endpackage

// File: rtl/lane_boundary_map.sv
module lane_boundary_map
  import simd_add_pkg::*;
#(
  parameter int NUM_SLICES = 16
) (
  input  lane_mode_e              mode,
  output logic [NUM_SLICES-1:0]   cut_vec,   // slice starts a lane: carry-in forced to 0
  output logic [NUM_SLICES-1:0]   top_vec    // slice ends a lane: its carry is reported
);

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_map
    always_comb begin
      case (mode)
        LANE_W8: begin
          cut_vec[i] = 1'b1;
          top_vec[i] = 1'b1;
        end
        LANE_W16: begin
          cut_vec[i] = (i % 2) == 0;
          top_vec[i] = (i % 2) == 1;
        end
        default: begin
          cut_vec[i] = (i % 4) == 0;
          top_vec[i] = (i % 4) == 3;
        end
      endcase
    end

    // R5: a lane always starts right after the previous lane ends
    if (i > 0) begin : g_chk
      always_comb begin
        a_r5_cut_follows_top: assert (cut_vec[i] == top_vec[i-1]);
      end
    end else begin : g_chk0
      always_comb begin
        a_r5_first_slice_cut: assert (cut_vec[0]);
      end
    end
  end

endmodule

// File: rtl/slice_add.sv
module slice_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);

  logic [W:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    s    = full[W-1:0];
    cout = full[W];
  end

endmodule

// File: rtl/partitioned_carry_chain.sv
module partitioned_carry_chain
  import simd_add_pkg::*;
#(
  parameter int WORD_W = 128,
  localparam int NUM_SLICES = WORD_W / SLICE_W
) (
  input  logic [WORD_W-1:0]     a,
  input  logic [WORD_W-1:0]     b,
  input  logic [NUM_SLICES-1:0] cut_vec,
  input  logic [NUM_SLICES-1:0] top_vec,
  output logic [WORD_W-1:0]     sum,
  output logic [NUM_SLICES-1:0] carry_vec
);

  logic [NUM_SLICES:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    logic              cin_i;
    logic [SLICE_W-1:0] s_i;

    assign cin_i = cut_vec[i] ? 1'b0 : cy[i];

    slice_add #(.W(SLICE_W)) u_add (
      .a    (a[i*SLICE_W +: SLICE_W]),
      .b    (b[i*SLICE_W +: SLICE_W]),
      .cin  (cin_i),
      .s    (s_i),
      .cout (cy[i+1])
    );

    assign sum[i*SLICE_W +: SLICE_W] = s_i;
    assign carry_vec[i] = top_vec[i] & cy[i+1];

    // R1: a single-slice lane is a plain byte add
    always_comb begin
      if (cut_vec[i] && top_vec[i]) begin
        a_r1_byte_lane: assert (s_i == SLICE_W'(a[i*SLICE_W +: SLICE_W] + b[i*SLICE_W +: SLICE_W]));
      end
    end
  end

endmodule

// File: rtl/result_stage.sv
module result_stage #(
  parameter int WORD_W     = 128,
  parameter int NUM_SLICES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [WORD_W-1:0]     sum_d,
  input  logic [NUM_SLICES-1:0] carry_d,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     sum_q,
  output logic [NUM_SLICES-1:0] carry_q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      sum_q   <= sum_d;
      carry_q <= carry_d;
    end
  end

  // R7: an accepted beat appears on the next cycle
  a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R8: stalled output holds
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(sum_q) && $stable(carry_q)));

  // R8: empty register always accepts
  a_r8_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int WORD_W = 128,
  localparam int NUM_SLICES = WORD_W / SLICE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [1:0]            lane_mode,
  input  logic [WORD_W-1:0]     opnd_a,
  input  logic [WORD_W-1:0]     opnd_b,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [WORD_W-1:0]     sum_o,
  output logic [NUM_SLICES-1:0] carry_o
);

  lane_mode_e             mode;
  logic [NUM_SLICES-1:0]  cut_vec;
  logic [NUM_SLICES-1:0]  top_vec;
  logic [WORD_W-1:0]      sum_c;
  logic [NUM_SLICES-1:0]  carry_c;

  assign mode = lane_mode_e'(lane_mode);

  initial begin
    a_word_multiple_of_32: assert (WORD_W % 32 == 0 && WORD_W >= 32);
  end

  lane_boundary_map #(.NUM_SLICES(NUM_SLICES)) u_map (
    .mode    (mode),
    .cut_vec (cut_vec),
    .top_vec (top_vec)
  );

  partitioned_carry_chain #(.WORD_W(WORD_W)) u_chain (
    .a         (opnd_a),
    .b         (opnd_b),
    .cut_vec   (cut_vec),
    .top_vec   (top_vec),
    .sum       (sum_c),
    .carry_vec (carry_c)
  );

  result_stage #(.WORD_W(WORD_W), .NUM_SLICES(NUM_SLICES)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .sum_d     (sum_c),
    .carry_d   (carry_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .sum_q     (sum_o),
    .carry_q   (carry_o)
  );

endmodule

// File: tb/simd_lane_adder_tb_top.sv
`timescale 1ns/1ps
module simd_lane_adder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic         in_valid = 1'b0;
  logic         out_ready = 1'b1;
  logic [1:0]   lane_mode = 2'b00;
  logic [255:0] a_d = '0;
  logic [255:0] b_d = '0;

  logic         rdy_s, vld_s;
  logic [127:0] sum_s;
  logic [15:0]  cy_s;
  logic         rdy_w, vld_w;
  logic [255:0] sum_w;
  logic [31:0]  cy_w;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  simd_lane_adder #(.WORD_W(128)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_s),
    .lane_mode(lane_mode), .opnd_a(a_d[127:0]), .opnd_b(b_d[127:0]),
    .out_valid(vld_s), .out_ready(out_ready), .sum_o(sum_s), .carry_o(cy_s));

  simd_lane_adder #(.WORD_W(256)) dut_w_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_w),
    .lane_mode(lane_mode), .opnd_a(a_d), .opnd_b(b_d),
    .out_valid(vld_w), .out_ready(out_ready), .sum_o(sum_w), .carry_o(cy_w));

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: per-lane modular add over nbits
  task automatic calc(input logic [255:0] a, input logic [255:0] b, input int w, input int nbits,
                      output logic [255:0] s, output logic [31:0] c);
    logic [31:0] m;
    logic [255:0] ta, tb;
    logic [32:0] t;
    s = '0;
    c = '0;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    for (int l = 0; l < nbits / w; l++) begin
      ta = a >> (l * w);
      tb = b >> (l * w);
      t = {1'b0, ta[31:0] & m} + {1'b0, tb[31:0] & m};
      s = s | (256'(t[31:0] & m) << (l * w));
      c[l * (w / 8) + (w / 8) - 1] = t[w];
    end
  endtask

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 32;
  endfunction

  function automatic string tag_of(input logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic apply(input logic [255:0] a, input logic [255:0] b, input logic [1:0] m, input string extra);
    logic [255:0] es, esw;
    logic [31:0]  ec, ecw;
    int w;
    w = width_of(m);
    calc(a, b, w, 128, es, ec);
    calc(a, b, w, 256, esw, ecw);
    @(negedge clk);
    a_d = a; b_d = b; lane_mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(vld_s == 1'b1, "R7 out_valid after beat", 256'(vld_s), 256'(1));
    check(sum_s == es[127:0], {tag_of(m), " ", extra, " sum"}, 256'(sum_s), es);
    check(cy_s == ec[15:0], {"R6 carry ", tag_of(m)}, 256'(cy_s), 256'(ec[15:0]));
    check(sum_w == esw && cy_w == ecw, {"R10 wide ", tag_of(m)}, sum_w, esw);
  endtask

  logic [255:0] lfsr = 256'h1F2E3D4C5B6A7988_0123456789ABCDEF_FEDCBA9876543210_A5A55A5AC3C33C3C;
  function automatic logic [255:0] step(input logic [255:0] x);
    return {x[254:0], x[255] ^ x[253] ^ x[250] ^ x[245]};
  endfunction

  initial begin
    logic [255:0] ones_lane, one_lane, pa, pb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(vld_s == 1'b0 && rdy_s == 1'b1, "R9 reset state", 256'({vld_s, rdy_s}), 256'(1));

    for (int m = 0; m < 4; m++) begin
      int w;
      w = width_of(2'(m));
      // R5 boundary: all-ones lanes plus one in every lane
      ones_lane = '1;
      one_lane = '0;
      for (int l = 0; l < 256 / w; l++) one_lane[l * w] = 1'b1;
      apply(ones_lane, one_lane, 2'(m), "R5 wrap");
      check(sum_s == '0, "R5 lanes wrap to zero", 256'(sum_s), 256'(0));
      // alternate lanes overflow; neighbour must stay intact
      pa = '0; pb = '0;
      for (int l = 0; l < 256 / w; l += 2) begin
        for (int k = 0; k < w; k++) pa[l * w + k] = 1'b1;
        pb[l * w] = 1'b1;
      end
      apply(pa, pb, 2'(m), "R5 neighbour");
      apply('0, '0, 2'(m), "zero");
      apply('1, '1, 2'(m), "max");
      for (int k = 0; k < 60; k++) begin
        lfsr = step(lfsr); pa = lfsr;
        lfsr = step(lfsr); pb = lfsr ^ {lfsr[127:0], lfsr[255:128]};
        apply(pa, pb, 2'(m), "pattern");
      end
    end

    // R7: idle cycle drops out_valid
    @(negedge clk);
    check(vld_s == 1'b0, "R7 idle drops valid", 256'(vld_s), 256'(0));

    // R8 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    a_d = {8{32'h0000_0010}}; b_d = {8{32'h0000_0001}}; lane_mode = 2'b10; in_valid = 1'b1;
    @(negedge clk);
    a_d = {8{32'h0000_0020}};
    check(vld_s == 1'b1 && sum_s == {4{32'h11}}, "R8 first beat held", 256'(sum_s), 256'({4{32'h11}}));
    check(rdy_s == 1'b0, "R8 in_ready low when stalled", 256'(rdy_s), 256'(0));
    repeat (3) @(negedge clk);
    check(vld_s == 1'b1 && sum_s == {4{32'h11}}, "R8 still held", 256'(sum_s), 256'({4{32'h11}}));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(vld_s == 1'b1 && sum_s == {4{32'h21}}, "R8 second beat after release", 256'(sum_s), 256'({4{32'h21}}));
    @(negedge clk);
    check(vld_s == 1'b0, "R8 drained", 256'(vld_s), 256'(0));

    // R9 reset while holding
    out_ready = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(vld_s == 1'b0 && rdy_s == 1'b1, "R9 reset clears valid", 256'({vld_s, rdy_s}), 256'(1));
    out_ready = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule